// File: doc/BRIEF.md
# Memory-Mapped I/O Address Decoder

This block sits behind a processor's memory address register. It turns each access into one of two things: a transfer to main memory, or a one-cycle access to one of four device registers. The four device registers are keyboard status, keyboard data, display status and display data, and they sit at four fixed word addresses at the top of the 16-bit space. Every other address goes to memory.

The inputs are an access enable, a read/write flag, the byte address and the write data. From these the decoder drives a memory enable, a 2-bit select for the read-data multiplexer, and a load enable for each device register that software may write. The block also contains the device registers and a small word memory with a fixed multi-cycle latency. This lets the decode be observed over time through a ready output and the returned read data.

Keyboard hardware is represented only by a port that loads a character into the keyboard data register. The display is represented by a port that shows the display data register.

Top module: `mmio_decode_top`

## Requirements
- R1: Device slots sit at IO_BASE+0 (keyboard status), IO_BASE+2 (keyboard data), IO_BASE+4 (display status) and IO_BASE+6 (display data), with IO_BASE = 0xFE00 by default. Only these exact even addresses hit a device.
- R2: While `acc_en` is 0, `mem_en`, all three load enables and `ready` are 0, `rd_sel` is 2'b00, `rd_data` is 0, and no register or memory word changes.
- R3: `mem_en` is 1 exactly when `acc_en` is 1 and the address is not a device slot. Odd addresses in the device page and addresses above IO_BASE+7 count as memory.
- R4: `rd_sel` encodes memory as 2'b00, keyboard data as 2'b01, keyboard status as 2'b10 and display status as 2'b11. It takes a non-memory value only on an enabled read of those three slots. It is 2'b00 on every write, and `rd_data` carries the selected register in the same cycle.
- R5: An enabled write to keyboard status, display status or display data raises only that register's load enable (`ld_kstat`, `ld_dstat`, `ld_ddata`) in that cycle. The register holds `wr_data` from the next cycle on, and at most one load enable is high at any time.
- R6: An enabled write to the keyboard data slot raises no load enable and no memory enable. It changes neither the keyboard data register nor any memory word.
- R7: An enabled read of the display data slot returns `rd_data` = 0, with `rd_sel` = 2'b00 and `mem_en` = 0.
- R8: Any enabled device access has `ready` = 1 in the same cycle it is presented.
- R9: A memory access with `acc_en` held raises `ready` in its MEM_LAT-th cycle (5 by default) and never earlier. Read data is valid in that cycle, a write commits at the end of it, and dropping `acc_en` early cancels the access, so the next access takes the full latency again.
- R10: When `kbd_char_ld` is 1, the keyboard data register takes `kbd_char` at the clock edge.
- R11: Reset clears all device registers, all memory words and the latency counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access enable for the current cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Byte address of the access |
| wr_data | input | 16 | Write data |
| kbd_char_ld | input | 1 | Loads a new character into keyboard data |
| kbd_char | input | 16 | Character value from the keyboard side |
| mem_en | output | 1 | Memory enable |
| rd_sel | output | 2 | Read-data multiplexer select |
| ld_kstat | output | 1 | Load enable, keyboard status |
| ld_dstat | output | 1 | Load enable, display status |
| ld_ddata | output | 1 | Load enable, display data |
| rd_data | output | 16 | Read data returned to the processor |
| ready | output | 1 | Access completes this cycle |
| disp_data | output | 16 | Current display data register |

## Verification
The decode outputs (`mem_en`, `rd_sel`, the load enables, device `ready` and device `rd_data`) are combinational and due in the same cycle the access is driven. Register writes become visible through `rd_data` or `disp_data` one cycle later. Memory `ready` and memory read data are due in the fifth consecutive cycle of a held access. The bench drives each cycle just after the falling edge and queues one expected item per cycle from a register model kept in the bench. A monitor then checks that item two nanoseconds later, in the same cycle, so a result is compared only in the cycle it is due, and memory read data only in the ready cycle.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

   // read-data multiplexer select; encoding is visible at the top port
   typedef enum logic [1:0] {
      SEL_MEM   = 2'b00,
      SEL_KDATA = 2'b01,
      SEL_KSTAT = 2'b10,
      SEL_DSTAT = 2'b11
   } rd_sel_e;

   // device slot index taken from address bits [2:1]
   typedef enum logic [1:0] {
      SLOT_KSTAT = 2'd0,
      SLOT_KDATA = 2'd1,
      SLOT_DSTAT = 2'd2,
      SLOT_DDATA = 2'd3
   } slot_e;

   typedef struct packed {
      logic kstat;
      logic dstat;
      logic ddata;
   } ld_vec_t;

endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
   import mmio_pkg::*;
#(
   parameter int              ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] IO_BASE = 'hFE00
) (
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              dev_hit,
   output logic              mem_en,
   output rd_sel_e           rd_sel,
   output ld_vec_t           ld
);

   localparam int PAGE_LSB = 3;

   if (IO_BASE[PAGE_LSB-1:0] != '0) begin : g_base_chk
      $error("IO_BASE must be aligned to an 8-byte device page");
   end

   slot_e slot;

   assign dev_hit = (acc_addr[ADDR_W-1:PAGE_LSB] == IO_BASE[ADDR_W-1:PAGE_LSB])
                    && !acc_addr[0];
   assign slot    = slot_e'(acc_addr[PAGE_LSB-1:1]);
   assign mem_en  = acc_en && !dev_hit;

   always_comb begin
      rd_sel = SEL_MEM;
      ld     = '0;
      if (acc_en && dev_hit) begin
         if (acc_wr) begin
            case (slot)
               SLOT_KSTAT: ld.kstat = 1'b1;
               SLOT_DSTAT: ld.dstat = 1'b1;
               SLOT_DDATA: ld.ddata = 1'b1;
               default:    ;
            endcase
         end else begin
            case (slot)
               SLOT_KSTAT: rd_sel = SEL_KSTAT;
               SLOT_KDATA: rd_sel = SEL_KDATA;
               SLOT_DSTAT: rd_sel = SEL_DSTAT;
               default:    rd_sel = SEL_MEM;
            endcase
         end
      end
   end

endmodule

// File: rtl/mmio_dev_regs.sv
module mmio_dev_regs
   import mmio_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ld_vec_t           ld,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              kchar_ld,
   input  logic [DATA_W-1:0] kchar,
   output logic [DATA_W-1:0] kstat_q,
   output logic [DATA_W-1:0] kdata_q,
   output logic [DATA_W-1:0] dstat_q,
   output logic [DATA_W-1:0] ddata_q
);

   localparam int N_WR = 3;

   logic [N_WR-1:0]   ld_bits;
   logic [DATA_W-1:0] wreg [N_WR];

   assign ld_bits = {ld.kstat, ld.dstat, ld.ddata};

   for (genvar i = 0; i < N_WR; i++) begin : g_wreg
      always_ff @(posedge clk) begin
         if (!rst_n)          wreg[i] <= '0;
         else if (ld_bits[i]) wreg[i] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        kdata_q <= '0;
      else if (kchar_ld) kdata_q <= kchar;
   end

   assign kstat_q = wreg[2];
   assign dstat_q = wreg[1];
   assign ddata_q = wreg[0];

endmodule

// File: rtl/mmio_mem_model.sv
module mmio_mem_model #(
   parameter int DATA_W  = 16,
   parameter int MEM_AW  = 6,
   parameter int MEM_LAT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_en,
   input  logic              wr,
   input  logic [MEM_AW-1:0] idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);

   localparam int WORDS = 1 << MEM_AW;
   localparam int CNT_W = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1;

   if (MEM_LAT < 1) begin : g_lat_chk
      $error("MEM_LAT must be at least 1");
   end

   logic [DATA_W-1:0] mem [WORDS];

   if (MEM_LAT == 1) begin : g_single
      assign done = mem_en;
   end else begin : g_multi
      logic [CNT_W-1:0] cnt;
      assign done = mem_en && (cnt == CNT_W'(MEM_LAT - 1));
      always_ff @(posedge clk) begin
         if (!rst_n || !mem_en || done) cnt <= '0;
         else                          cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else if (done && wr) begin
         mem[idx] <= wdata;
      end
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/mmio_decode_top.sv
module mmio_decode_top
   import mmio_pkg::*;
#(
   parameter int                ADDR_W  = 16,
   parameter int                DATA_W  = 16,
   parameter logic [ADDR_W-1:0] IO_BASE = 'hFE00,
   parameter int                MEM_AW  = 6,
   parameter int                MEM_LAT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              kbd_char_ld,
   input  logic [DATA_W-1:0] kbd_char,
   output logic              mem_en,
   output logic [1:0]        rd_sel,
   output logic              ld_kstat,
   output logic              ld_dstat,
   output logic              ld_ddata,
   output logic [DATA_W-1:0] rd_data,
   output logic              ready,
   output logic [DATA_W-1:0] disp_data
);

   if (ADDR_W < 4 || MEM_AW < 1 || MEM_AW + 1 > ADDR_W) begin : g_geom_chk
      $error("address geometry parameters are inconsistent");
   end

   logic              dev_hit;
   rd_sel_e           sel;
   ld_vec_t           ld;
   logic              mem_done;
   logic [DATA_W-1:0] mem_q, kstat_q, kdata_q, dstat_q, ddata_q;

   mmio_addr_decode #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) dec_i (
      .acc_en   (acc_en),
      .acc_wr   (acc_wr),
      .acc_addr (acc_addr),
      .dev_hit  (dev_hit),
      .mem_en   (mem_en),
      .rd_sel   (sel),
      .ld       (ld)
   );

   mmio_dev_regs #(.DATA_W(DATA_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ld),
      .wr_data  (wr_data),
      .kchar_ld (kbd_char_ld),
      .kchar    (kbd_char),
      .kstat_q  (kstat_q),
      .kdata_q  (kdata_q),
      .dstat_q  (dstat_q),
      .ddata_q  (ddata_q)
   );

   mmio_mem_model #(.DATA_W(DATA_W), .MEM_AW(MEM_AW), .MEM_LAT(MEM_LAT)) mem_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .mem_en (mem_en),
      .wr     (acc_wr),
      .idx    (acc_addr[MEM_AW:1]),
      .wdata  (wr_data),
      .rdata  (mem_q),
      .done   (mem_done)
   );

   always_comb begin
      case (sel)
         SEL_KSTAT: rd_data = kstat_q;
         SEL_KDATA: rd_data = kdata_q;
         SEL_DSTAT: rd_data = dstat_q;
         default:   rd_data = mem_en ? mem_q : '0;
      endcase
   end

   assign rd_sel    = sel;
   assign ld_kstat  = ld.kstat;
   assign ld_dstat  = ld.dstat;
   assign ld_ddata  = ld.ddata;
   assign ready     = (acc_en && dev_hit) || mem_done;
   assign disp_data = ddata_q;

endmodule

// File: rtl/mmio_decode_chk.sv
module mmio_decode_chk #(
   parameter int                ADDR_W  = 16,
   parameter int                DATA_W  = 16,
   parameter logic [ADDR_W-1:0] IO_BASE = 'hFE00,
   parameter int                MEM_LAT = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_en,
   input logic              acc_wr,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              mem_en,
   input logic [1:0]        rd_sel,
   input logic              ld_kstat,
   input logic              ld_dstat,
   input logic              ld_ddata,
   input logic [DATA_W-1:0] rd_data,
   input logic              ready,
   input logic [DATA_W-1:0] disp_data
);

   localparam logic [ADDR_W-1:0] A_KDATA = IO_BASE + ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_DDATA = IO_BASE + ADDR_W'(6);

   logic [31:0] run;
   logic        any_ld;
   logic        dev_addr;

   assign any_ld   = ld_kstat || ld_dstat || ld_ddata;
   assign dev_addr = (acc_addr == IO_BASE) || (acc_addr == IO_BASE + ADDR_W'(2)) ||
                     (acc_addr == IO_BASE + ADDR_W'(4)) || (acc_addr == A_DDATA);

   always_ff @(posedge clk) begin
      if (!rst_n || !mem_en || ready) run <= '0;
      else                            run <= run + 1;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_en |-> (!mem_en && !any_ld && !ready && rd_sel == 2'b00 && rd_data == '0)); // R2

   AST_MEM_NOT_DEV: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (!any_ld && rd_sel == 2'b00 && !dev_addr)); // R3

   AST_LD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ld_kstat, ld_dstat, ld_ddata})); // R5

   AST_LD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      any_ld |-> (acc_en && acc_wr && rd_sel == 2'b00)); // R5

   AST_DDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_ddata |=> $stable(disp_data)); // R5

   AST_KDATA_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_wr && acc_addr == A_KDATA) |-> (!any_ld && !mem_en)); // R6

   AST_DDATA_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_wr && acc_addr == A_DDATA) |-> (rd_data == '0 && !mem_en)); // R7

   AST_DEV_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && dev_addr) |-> ready); // R8

   AST_MEM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && ready) |-> (run == 32'(MEM_LAT - 1))); // R9

   AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && run < 32'(MEM_LAT - 1)) |-> !ready); // R9

endmodule

bind mmio_decode_top mmio_decode_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .IO_BASE(IO_BASE),
   .MEM_LAT(MEM_LAT)
) chk_i (.*);

// File: tb/mmio_decode_top_tb_top.sv
`timescale 1ns/1ps
module mmio_decode_top_tb_top;

   localparam int LAT = 5;

   typedef struct packed {
      logic        mem_en;
      logic [1:0]  sel;
      logic        lk;
      logic        ld;
      logic        ldd;
      logic        rdy;
      logic        chk_rd;
      logic [15:0] rd;
      logic [15:0] disp;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0, acc_wr = 1'b0, kbd_char_ld = 1'b0;
   logic [15:0] acc_addr = '0, wr_data = '0, kbd_char = '0;
   logic        mem_en, ld_kstat, ld_dstat, ld_ddata, ready;
   logic [1:0]  rd_sel;
   logic [15:0] rd_data, disp_data;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   exp_t  exp_q[$];
   string tag_q[$];

   logic [15:0] m_kstat = '0, m_kdata = '0, m_dstat = '0, m_ddata = '0;
   logic [15:0] m_mem [64];

   always #2.5 clk = ~clk;

   mmio_decode_top dut_i (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .wr_data(wr_data), .kbd_char_ld(kbd_char_ld),
      .kbd_char(kbd_char), .mem_en(mem_en), .rd_sel(rd_sel),
      .ld_kstat(ld_kstat), .ld_dstat(ld_dstat), .ld_ddata(ld_ddata),
      .rd_data(rd_data), .ready(ready), .disp_data(disp_data)
   );

   // driver: one call per cycle, expected outputs from the requirement model
   task automatic cyc(input bit en, input bit wr, input logic [15:0] addr,
                      input logic [15:0] wd, input bit kld, input logic [15:0] kch,
                      input bit mrdy, input string tag);
      exp_t e;
      bit   dev;
      @(negedge clk);
      acc_en = en; acc_wr = wr; acc_addr = addr; wr_data = wd;
      kbd_char_ld = kld; kbd_char = kch;
      dev = (addr[15:3] == 13'h1FC0) && !addr[0];
      e = '0;
      e.disp   = m_ddata;
      e.mem_en = en && !dev;
      e.chk_rd = 1'b1;
      if (en && dev && !wr) begin
         case (addr[2:1])
            2'd0: begin e.sel = 2'b10; e.rd = m_kstat; end
            2'd1: begin e.sel = 2'b01; e.rd = m_kdata; end
            2'd2: begin e.sel = 2'b11; e.rd = m_dstat; end
            default: begin e.sel = 2'b00; e.rd = 16'h0000; end
         endcase
      end else if (e.mem_en) begin
         e.chk_rd = mrdy && !wr;
         e.rd     = m_mem[addr[6:1]];
      end
      if (en && dev && wr) begin
         e.lk  = (addr[2:1] == 2'd0);
         e.ld  = (addr[2:1] == 2'd2);
         e.ldd = (addr[2:1] == 2'd3);
      end
      e.rdy = (en && dev) || (e.mem_en && mrdy);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      if (e.lk)  m_kstat = wd;
      if (e.ld)  m_dstat = wd;
      if (e.ldd) m_ddata = wd;
      if (e.mem_en && wr && mrdy) m_mem[addr[6:1]] = wd;
      if (kld) m_kdata = kch;
   endtask

   task automatic idle(input string tag);
      cyc(1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, tag);
   endtask

   task automatic mem_acc(input bit wr, input logic [15:0] addr,
                          input logic [15:0] wd, input string tag);
      for (int c = 0; c < LAT; c++)
         cyc(1'b1, wr, addr, wd, 1'b0, 16'h0000, (c == LAT - 1), tag);
   endtask

   // monitor: compares mid-cycle, after the driver has settled the inputs
   initial begin
      exp_t  e, a;
      string t;
      forever begin
         @(negedge clk);
         #2;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {mem_en, rd_sel, ld_kstat, ld_dstat, ld_ddata, ready, e.chk_rd,
                 (e.chk_rd ? rd_data : 16'h0000), disp_data};
            if (!e.chk_rd) e.rd = 16'h0000;
            checks++;
            if (a !== e) begin
               failures++;
               $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
         end
      end
   end

   initial begin
      #(5.0 * 50000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) m_mem[i] = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle("R11 reset idle");
      cyc(1, 0, 16'hFE00, 0, 0, 0, 0, "R11 R1 kstat reset value");
      cyc(1, 0, 16'hFE06, 0, 0, 0, 0, "R11 ddata reset");
      // writes to writable device registers
      cyc(1, 1, 16'hFE00, 16'h8001, 0, 0, 0, "R5 R1 write kstat");
      cyc(1, 1, 16'hFE04, 16'h4000, 0, 0, 0, "R5 write dstat");
      cyc(1, 1, 16'hFE06, 16'h0041, 0, 0, 0, "R5 write ddata");
      idle("R5 ddata visible");
      cyc(1, 0, 16'hFE00, 0, 0, 0, 0, "R4 read kstat");
      cyc(1, 0, 16'hFE04, 0, 0, 0, 0, "R4 read dstat");
      cyc(1, 0, 16'hFE06, 0, 0, 0, 0, "R7 read ddata zero");
      // keyboard data write ignored
      cyc(1, 1, 16'hFE02, 16'hBEEF, 0, 0, 0, "R6 kdata write ignored");
      cyc(1, 0, 16'hFE02, 0, 0, 0, 0, "R6 kdata unchanged");
      mem_acc(0, 16'h0002, 0, "R6 memory untouched");
      idle("R2 gap");
      // keyboard side load
      cyc(0, 0, 16'h0000, 0, 1, 16'h0061, 0, "R10 kbd char load");
      cyc(1, 0, 16'hFE02, 0, 0, 0, 0, "R10 R8 read kdata");
      // enable low on device write
      cyc(0, 1, 16'hFE00, 16'hDEAD, 0, 0, 0, "R2 disabled write");
      cyc(0, 0, 16'hFE04, 0, 0, 0, 0, "R2 disabled read");
      cyc(1, 0, 16'hFE00, 0, 0, 0, 0, "R2 kstat unchanged");
      // memory accesses
      mem_acc(1, 16'h0002, 16'h1234, "R9 mem write");
      idle("R9 gap");
      mem_acc(0, 16'h0002, 0, "R9 mem read");
      mem_acc(1, 16'hFE08, 16'h5555, "R3 R9 write above device page");
      mem_acc(0, 16'hFE08, 0, "R3 R9 read above device page");
      mem_acc(0, 16'hFE01, 0, "R3 odd device-page address");
      mem_acc(0, 16'h3000, 0, "R3 low memory");
      // cancelled access then a full one
      cyc(1, 1, 16'h0004, 16'h7777, 0, 0, 0, "R9 cancelled write c0");
      cyc(1, 1, 16'h0004, 16'h7777, 0, 0, 0, "R9 cancelled write c1");
      idle("R9 cancel gap");
      mem_acc(0, 16'h0004, 0, "R9 read after cancel");
      cyc(1, 1, 16'hFE06, 16'h00AA, 0, 0, 0, "R5 ddata second write");
      idle("R5 ddata second visible");
      repeat (3) @(negedge clk);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule